// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit logical address into a physical address using a two-step scheme. The four most significant bits pick one of sixteen segments. Each segment points at its own page table and carries a limit on how many entries of that table are in use. The eight middle bits are the page index within the segment. The twelve least significant bits are the byte offset, and they pass through unchanged.

A translation request is accepted only while the block is idle. The page index is first checked against the segment's limit. If the index is out of range, the block reports a limit fault and does not touch memory. If the index is in range, the block reads one page-table entry over a simple request/response memory port. It then returns either the physical address or an invalid-page fault.

Software loads the per-segment table pointers and limits through a write port indexed by segment number. That port may only be used while no translation is in flight.

Top module: `seg_page_xlate`

## Requirements
- R1: The logical address is split as segment = bits [23:20], page = bits [19:12], offset = bits [11:0]. The offset appears unchanged in bits [11:0] of every successful physical address.
- R2: When `cfgWe` is high at a clock edge, the table pointer and limit of segment `cfgSeg` are loaded from `cfgBase` and `cfgBound`. Reset clears every pointer and limit to 0, so any page of an unconfigured segment faults on its limit. A later write replaces both values, and subsequent translations use the new ones.
- R3: A page index greater than or equal to the segment's limit gives `rspFault` = 1 (limit fault) with `rspPhysAddr` = 0. In this case no memory request is issued, and `rspValid` rises at the first clock edge after the acceptance edge.
- R4: For an in-range page, exactly one memory read is issued, at address = segment pointer + page × 4.
- R5: A page-table entry has its valid flag in bit 0 and the frame number in bits [31:12]. When the valid flag is set, the response carries `rspFault` = 0 and `rspPhysAddr` = {frame number, offset}. Fault code 3 never appears.
- R6: When the valid flag of the entry is clear, the response carries `rspFault` = 2 with `rspPhysAddr` = 0.
- R7: `reqReady` is high only while idle, so only one translation is in flight at a time. `rspValid` is a one-cycle pulse. On the memory path, `rspValid` rises at the clock edge that samples `memRspValid` high.
- R8: After reset, `reqReady` = 1, `rspValid` = 0 and `memReqValid` = 0.
- R9: `memReqValid` is a one-cycle pulse. It rises at the first clock edge after acceptance, and only during a translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 24 | Logical address |
| reqReady | output | 1 | Block idle; a request is taken at this edge |
| rspValid | output | 1 | Result pulse |
| rspPhysAddr | output | 32 | Translated physical address (0 on fault) |
| rspFault | output | 2 | 0 none, 1 limit fault, 2 invalid page |
| cfgWe | input | 1 | Segment register write enable |
| cfgSeg | input | 4 | Segment being written |
| cfgBase | input | 32 | Page-table physical pointer |
| cfgBound | input | 9 | Number of usable entries (0 to 256) |
| memReqValid | output | 1 | Page-table read request pulse |
| memReqAddr | output | 32 | Page-table entry address |
| memRspValid | input | 1 | Read data strobe |
| memRspData | input | 32 | Page-table entry |

## Verification
The cycle counter is the count of rising edges. A limit fault must produce its result exactly one cycle after the acceptance edge. On the memory path, the read request is due one cycle after acceptance, and the result is due in the cycle the bench's memory model returns data, which is two plus the model's latency after acceptance. The driver records the acceptance cycle and pushes each expected result with its due cycle. The monitor samples on the falling edge and compares value, fault code and arrival cycle. The memory model checks each read address against a queue filled by the driver, and the total read count is compared at the end to show that limit faults never reach memory.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_BOUND   = 2'd1,
    FAULT_INVALID = 2'd2
  } fault_e;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic capture;     // latch incoming logical address
    logic boundFault;  // record a limit fault
    logic pteLoad;     // record result built from the returned entry
  } ctrl_s;

endpackage

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  pageOk,
  input  logic  memRspValid,
  output logic  reqReady,
  output logic  memReqValid,
  output logic  rspValid,
  output ctrl_s strobes
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_ISSUE, S_WAIT, S_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:   if (reqValid) stateNext = S_LOOKUP;
      S_LOOKUP: stateNext = pageOk ? S_ISSUE : S_DONE;
      S_ISSUE:  stateNext = S_WAIT;
      S_WAIT:   if (memRspValid) stateNext = S_DONE;
      S_DONE:   stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.capture    = (state == S_IDLE) && reqValid;
    strobes.boundFault = (state == S_LOOKUP) && !pageOk;
    strobes.pteLoad    = (state == S_WAIT) && memRspValid;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign rspValid    = (state == S_DONE);

endmodule

// File: rtl/segx_datapath.sv
module segx_datapath
  import segx_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrl_s                           strobes,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0]   reqAddr,
  input  logic                            cfgWe,
  input  logic [SEG_W-1:0]                cfgSeg,
  input  logic [PA_W-1:0]                 cfgBase,
  input  logic [PAGE_W:0]                 cfgBound,
  input  logic [PTE_W-1:0]                memRspData,
  output logic                            pageOk,
  output logic [PA_W-1:0]                 pteAddr,
  output logic [PA_W-1:0]                 physAddr,
  output fault_e                          fault
);

  localparam int NSEG   = 1 << SEG_W;
  localparam int ADDR_W = SEG_W + PAGE_W + OFF_W;
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int ENT_SH = 2;  // 4-byte entries

  logic [PA_W-1:0]   segBase  [NSEG];
  logic [PAGE_W:0]   segBound [NSEG];
  logic [ADDR_W-1:0] curAddr;

  logic [SEG_W-1:0]  curSeg;
  logic [PAGE_W-1:0] curPage;
  logic [OFF_W-1:0]  curOff;

  assign curSeg  = curAddr[ADDR_W-1 -: SEG_W];
  assign curPage = curAddr[OFF_W +: PAGE_W];
  assign curOff  = curAddr[OFF_W-1:0];

  // Segment register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NSEG; s++) begin
        segBase[s]  <= '0;
        segBound[s] <= '0;
      end
    end else if (cfgWe) begin
      segBase[cfgSeg]  <= cfgBase;
      segBound[cfgSeg] <= cfgBound;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curAddr <= '0;
    else if (strobes.capture) curAddr <= reqAddr;
  end

  assign pageOk  = {1'b0, curPage} < segBound[curSeg];
  assign pteAddr = segBase[curSeg] + (PA_W'(curPage) << ENT_SH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      fault    <= FAULT_NONE;
    end else if (strobes.boundFault) begin
      physAddr <= '0;
      fault    <= FAULT_BOUND;
    end else if (strobes.pteLoad) begin
      if (memRspData[0]) begin
        physAddr <= {memRspData[OFF_W +: PFN_W], curOff};
        fault    <= FAULT_NONE;
      end else begin
        physAddr <= '0;
        fault    <= FAULT_INVALID;
      end
    end
  end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import segx_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] reqAddr,
  output logic                          reqReady,
  output logic                          rspValid,
  output logic [PA_W-1:0]               rspPhysAddr,
  output logic [1:0]                    rspFault,
  input  logic                          cfgWe,
  input  logic [SEG_W-1:0]              cfgSeg,
  input  logic [PA_W-1:0]               cfgBase,
  input  logic [PAGE_W:0]               cfgBound,
  output logic                          memReqValid,
  output logic [PA_W-1:0]               memReqAddr,
  input  logic                          memRspValid,
  input  logic [PTE_W-1:0]              memRspData
);

  ctrl_s  strobes;
  logic   pageOk;
  fault_e faultQ;

  segx_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .pageOk      (pageOk),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .strobes     (strobes)
  );

  segx_datapath #(
    .SEG_W (SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .cfgWe      (cfgWe),
    .cfgSeg     (cfgSeg),
    .cfgBase    (cfgBase),
    .cfgBound   (cfgBound),
    .memRspData (memRspData),
    .pageOk     (pageOk),
    .pteAddr    (memReqAddr),
    .physAddr   (rspPhysAddr),
    .fault      (faultQ)
  );

  assign rspFault = faultQ;

endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPhysAddr,
  input logic [1:0]      rspFault,
  input logic            memReqValid,
  input logic            memRspValid
);

  logic busy;
  logic readSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      readSeen <= 1'b0;
    end else begin
      if (reqValid && reqReady) busy <= 1'b1;
      else if (rspValid)        busy <= 1'b0;
      if (reqValid && reqReady) readSeen <= 1'b0;
      else if (memReqValid)     readSeen <= 1'b1;
    end
  end

  assert_reset_state_R8: assert property (@(posedge clk)
    !rstN |=> (reqReady && !rspValid && !memReqValid));

  assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  assert_rsp_owned_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_mem_owned_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  assert_mem_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_bound_no_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd1) |-> !readSeen);

  assert_read_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd1) |-> readSeen);

  assert_fault_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'd3));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPhysAddr == '0));

  assert_rsp_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && busy && readSeen) |=> rspValid);

endmodule

bind seg_page_xlate seg_page_xlate_chk #(.PA_W(PA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspPhysAddr (rspPhysAddr),
  .rspFault    (rspFault),
  .memReqValid (memReqValid),
  .memRspValid (memRspValid)
);

// File: tb/seg_page_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_page_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [23:0] reqAddr;
  logic        reqReady;
  logic        rspValid;
  logic [31:0] rspPhysAddr;
  logic [1:0]  rspFault;
  logic        cfgWe;
  logic [3:0]  cfgSeg;
  logic [31:0] cfgBase;
  logic [8:0]  cfgBound;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;

  always #2.5 clk = ~clk;

  seg_page_xlate dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspPhysAddr(rspPhysAddr),
    .rspFault(rspFault), .cfgWe(cfgWe), .cfgSeg(cfgSeg), .cfgBase(cfgBase),
    .cfgBound(cfgBound), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  fault;
    int          due;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] addrQ[$];
  logic [31:0] tbBase [16];
  int          tbBound[16];
  logic [31:0] mem [logic [31:0]];
  int cyc = 0, lat = 1, checks = 0, fails = 0, reads = 0, expReads = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  task automatic cfg(input int seg, input logic [31:0] base, input int bound);
    waitIdle();
    cfgWe = 1'b1; cfgSeg = seg[3:0]; cfgBase = base; cfgBound = bound[8:0];
    @(negedge clk);
    cfgWe = 1'b0;
    tbBase[seg] = base; tbBound[seg] = bound;
  endtask

  task automatic setPte(input int seg, input int page, input logic [19:0] pfn, input bit v);
    mem[tbBase[seg] + 32'(page) * 4] = {pfn, 11'd0, v};
  endtask

  task automatic xlate(input logic [23:0] a, input string tag);
    int seg, page, accCyc;
    logic [31:0] pteA, pte;
    exp_t e;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    seg = int'(a[23:20]); page = int'(a[19:12]);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    accCyc = cyc;
    chk(reqReady == 1'b0, "R7", "reqReady after accept", 64'(reqReady), 64'd0);
    e.tag = tag;
    if (page >= tbBound[seg]) begin
      e.pa = '0; e.fault = 2'd1; e.due = accCyc + 1;
    end else begin
      pteA = tbBase[seg] + 32'(page) * 4;
      pte  = mem.exists(pteA) ? mem[pteA] : 32'd0;
      addrQ.push_back(pteA);
      expReads++;
      e.due = accCyc + 2 + lat;
      if (pte[0]) begin e.pa = {pte[31:12], a[11:0]}; e.fault = 2'd0; end
      else        begin e.pa = '0; e.fault = 2'd2; end
    end
    expQ.push_back(e);
  endtask

  // memory model
  initial begin
    logic [31:0] a;
    memRspValid = 1'b0; memRspData = '0;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && memReqValid) begin
        reads++;
        a = memReqAddr;
        if (addrQ.size() == 0)
          chk(1'b0, "R4", "unexpected read at", 64'(a), 64'd0);
        else begin
          logic [31:0] ea;
          ea = addrQ.pop_front();
          chk(a == ea, "R4", "entry address", 64'(a), 64'(ea));
        end
        repeat (lat) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = mem.exists(a) ? mem[a] : 32'd0;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid === 1'b1) begin
        if (expQ.size() == 0)
          chk(1'b0, "R7", "response with none pending", 64'(rspPhysAddr), 64'd0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          chk(rspPhysAddr == e.pa, e.tag, "physical address", 64'(rspPhysAddr), 64'(e.pa));
          chk(rspFault == e.fault, e.tag, "fault code", 64'(rspFault), 64'(e.fault));
          chk(cyc == e.due, (e.fault == 2'd1) ? "R3" : "R7", "response cycle",
              64'(cyc), 64'(e.due));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    for (int s = 0; s < 16; s++) begin tbBase[s] = '0; tbBound[s] = 0; end
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0;
    cfgWe = 1'b0; cfgSeg = '0; cfgBase = '0; cfgBound = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "reqReady after reset", 64'(reqReady), 64'd1);
    chk(rspValid == 1'b0, "R8", "rspValid after reset", 64'(rspValid), 64'd0);
    chk(memReqValid == 1'b0, "R8", "memReqValid after reset", 64'(memReqValid), 64'd0);

    xlate(24'h300456, "R2");           // unconfigured segment: limit 0

    cfg(1,  32'h0001_0000, 4);
    cfg(2,  32'h8000_0000, 256);
    cfg(15, 32'h0000_0040, 1);
    cfg(0,  32'h0000_2000, 8);
    setPte(1, 0, 20'hABCDE, 1'b1);
    setPte(1, 1, 20'h00012, 1'b1);
    setPte(1, 2, 20'h55555, 1'b0);
    setPte(1, 3, 20'hFFFFF, 1'b1);
    setPte(2, 255, 20'h13579, 1'b1);
    setPte(2, 0, 20'h2468A, 1'b1);
    setPte(15, 0, 20'h00001, 1'b1);
    setPte(0, 5, 20'h0ABC0, 1'b1);

    lat = 1;
    xlate(24'h100123, "R5");
    xlate(24'h101FFF, "R1");
    xlate(24'h103000, "R3");           // last page inside limit
    xlate(24'h104ABC, "R3");           // first page beyond limit
    xlate(24'h102777, "R6");           // entry with valid clear
    xlate(24'h2FF800, "R5");           // full-size table, top page
    xlate(24'hF00FED, "R1");
    xlate(24'hF01000, "R3");
    xlate(24'hFC8001, "R3");
    xlate(24'h007010, "R6");           // in range, no entry stored

    waitIdle();
    lat = 4;
    xlate(24'h005321, "R4");
    xlate(24'h100000, "R4");
    xlate(24'h200FFF, "R5");

    cfg(1, 32'h0003_0000, 2);
    setPte(1, 1, 20'h7E7E7, 1'b1);
    lat = 2;
    xlate(24'h103123, "R2");           // was legal, now beyond new limit
    xlate(24'h101456, "R2");           // reads through new pointer
    xlate(24'h100456, "R2");           // no entry at new location

    waitIdle();
    repeat (4) @(negedge clk);
    chk(reads == expReads, "R3", "memory read count", 64'(reads), 64'(expReads));
    summary();
  end

endmodule